// File: doc/BRIEF.md
# Flag-Handshake Character Terminal Interface

This block sits between a character terminal and a small accumulator CPU. It holds one received character and one character waiting to be sent, each guarded by a single ready bit, plus the flip-flop that enables interrupts. The device writes a received character when the receive bit is clear and reads the pending transmit character when the transmit bit is clear. The CPU reaches the block only through decoded one-cycle instruction strobes.

The receive channel is a two-state machine. In `RX_EMPTY` (receive flag 0), a device write takes the character and moves to `RX_FULL` (flag 1). In `RX_FULL`, the CPU input strobe moves back to `RX_EMPTY`, and further device writes are ignored. The transmit channel is a two-state machine as well. `TX_READY` (transmit flag 1) goes to `TX_PENDING` (flag 0) on the CPU output strobe, which also latches the accumulator byte. `TX_PENDING` goes back to `TX_READY` when the device reads the character. An output strobe in `TX_PENDING` reloads the character and keeps the state.

The interrupt-enable machine has the states `IE_OFF` and `IE_ON`. The enable strobe moves it to `IE_ON`. The disable strobe or the external clear moves it to `IE_OFF`, and the external clear wins over the enable strobe. The interrupt request is raised while the machine is in `IE_ON` and either flag is 1. The skip request is combinational and asks the CPU to skip its next instruction.

Top module: `term_flag_io`

## Requirements
- R1: After reset the receive flag is 0, the transmit flag is 1, interrupts are disabled (`irq` 0), and both character registers hold 0.
- R2: A device write while the receive flag is 0 stores `dev_rx_char`, and the receive flag reads 1 from the next cycle on.
- R3: A device write while the receive flag is 1 is ignored: the stored character and the flag keep their values.
- R4: `acc_lo_out` always shows the stored receive character. The input strobe `cpu_inp` with the receive flag at 1 clears the flag from the next cycle on.
- R5: The output strobe `cpu_out` latches `acc_lo_in` into the transmit register shown on `dev_tx_char`, and the transmit flag reads 0 from the next cycle on. This holds in either transmit state.
- R6: A device read while the transmit flag is 0 sets the flag to 1 from the next cycle on. A device read while the flag is 1 has no effect.
- R7: `skip_req` is 1 in the same cycle when `cpu_ski` is high with the receive flag at 1, or when `cpu_sko` is high with the transmit flag at 1. Otherwise it is 0.
- R8: `cpu_ion` enables interrupts from the next cycle on. `cpu_iof` disables them from the next cycle on.
- R9: `cpu_clr_ien` disables interrupts from the next cycle on, even when `cpu_ion` is high in the same cycle.
- R10: `irq` is 1 exactly when interrupts are enabled and at least one of the two flags is 1.
- R11: When a device write and `cpu_inp` arrive together with the receive flag at 0, the write wins and the flag becomes 1. When `cpu_out` and a device read arrive together with the transmit flag at 0, the new character wins and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rx_wr | input | 1 | Device strobe: a received character is offered |
| dev_rx_char | input | 8 | Received character from the device |
| dev_tx_rd | input | 1 | Device strobe: the pending character is taken |
| dev_tx_char | output | 8 | Transmit register contents |
| rx_flag | output | 1 | Receive flag (1 = character waiting for the CPU) |
| tx_flag | output | 1 | Transmit flag (1 = CPU may send) |
| cpu_inp | input | 1 | Decoded input-character instruction |
| cpu_out | input | 1 | Decoded output-character instruction |
| cpu_ski | input | 1 | Decoded skip-on-receive-flag instruction |
| cpu_sko | input | 1 | Decoded skip-on-transmit-flag instruction |
| cpu_ion | input | 1 | Decoded interrupt-enable instruction |
| cpu_iof | input | 1 | Decoded interrupt-disable instruction |
| cpu_clr_ien | input | 1 | Interrupt-cycle clear of the enable, priority over `cpu_ion` |
| acc_lo_in | input | 8 | Accumulator low byte |
| acc_lo_out | output | 8 | Receive register toward the accumulator low byte |
| skip_req | output | 1 | Request to skip the next instruction |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that at most one of the six decoded CPU strobes is high in any cycle, because each comes from a single decoded instruction. The external interrupt clear is exempt from that rule and may coincide with any of them. The enable and disable strobes never both appear. The bench drives every strobe for exactly one cycle and issues CPU instructions one at a time, except where a scenario deliberately pairs the clear with the enable strobe or pairs a device strobe with a CPU strobe. All device and CPU inputs change away from the active clock edge.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

    localparam int unsigned CHAR_W_DEF = 8;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_t;

    typedef enum logic {
        TX_READY   = 1'b0,
        TX_PENDING = 1'b1
    } tx_state_t;

    typedef enum logic {
        IE_OFF = 1'b0,
        IE_ON  = 1'b1
    } ie_state_t;

endpackage

// File: rtl/term_rx_chan.sv
module term_rx_chan
    import term_io_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_wr,
    input  logic [CHAR_W-1:0] dev_char,
    input  logic              take,
    output logic              flag,
    output logic [CHAR_W-1:0] char_q
);

    rx_state_t state_q, state_d;
    logic      load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        flag    = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                flag = 1'b0;
                if (dev_wr) begin
                    load    = 1'b1;
                    state_d = RX_FULL;
                end
            end
            RX_FULL: begin
                flag = 1'b1;
                if (take) begin
                    state_d = RX_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q <= '0;
        end else if (load) begin
            char_q <= dev_char;
        end
    end

endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan
    import term_io_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [CHAR_W-1:0] acc_byte,
    input  logic              dev_rd,
    output logic              flag,
    output logic [CHAR_W-1:0] char_q
);

    tx_state_t state_q, state_d;
    logic      load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = send;
        flag    = 1'b1;
        unique case (state_q)
            TX_READY: begin
                flag = 1'b1;
                if (send) begin
                    state_d = TX_PENDING;
                end
            end
            TX_PENDING: begin
                flag = 1'b0;
                if (dev_rd && !send) begin
                    state_d = TX_READY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q <= '0;
        end else if (load) begin
            char_q <= acc_byte;
        end
    end

endmodule

// File: rtl/term_ie_ctl.sv
module term_ie_ctl
    import term_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic force_clr,
    output logic enabled
);

    ie_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        enabled = 1'b0;
        unique case (state_q)
            IE_OFF: begin
                enabled = 1'b0;
                if (set_en && !force_clr) begin
                    state_d = IE_ON;
                end
            end
            IE_ON: begin
                enabled = 1'b1;
                if (force_clr || clr_en) begin
                    state_d = IE_OFF;
                end
            end
        endcase
    end

endmodule

// File: rtl/term_flag_io.sv
module term_flag_io
    import term_io_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rx_wr,
    input  logic [CHAR_W-1:0] dev_rx_char,
    input  logic              dev_tx_rd,
    output logic [CHAR_W-1:0] dev_tx_char,
    output logic              rx_flag,
    output logic              tx_flag,
    input  logic              cpu_inp,
    input  logic              cpu_out,
    input  logic              cpu_ski,
    input  logic              cpu_sko,
    input  logic              cpu_ion,
    input  logic              cpu_iof,
    input  logic              cpu_clr_ien,
    input  logic [CHAR_W-1:0] acc_lo_in,
    output logic [CHAR_W-1:0] acc_lo_out,
    output logic              skip_req,
    output logic              irq
);

    logic ien_q;

    term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_wr   (dev_rx_wr),
        .dev_char (dev_rx_char),
        .take     (cpu_inp),
        .flag     (rx_flag),
        .char_q   (acc_lo_out)
    );

    term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .send     (cpu_out),
        .acc_byte (acc_lo_in),
        .dev_rd   (dev_tx_rd),
        .flag     (tx_flag),
        .char_q   (dev_tx_char)
    );

    term_ie_ctl u_ie (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (cpu_ion),
        .clr_en    (cpu_iof),
        .force_clr (cpu_clr_ien),
        .enabled   (ien_q)
    );

    assign skip_req = (cpu_ski & rx_flag) | (cpu_sko & tx_flag);
    assign irq      = ien_q & (rx_flag | tx_flag);

endmodule

// File: rtl/term_flag_io_chk.sv
module term_flag_io_chk #(
    parameter int unsigned CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_rx_wr,
    input logic [CHAR_W-1:0] dev_rx_char,
    input logic              dev_tx_rd,
    input logic [CHAR_W-1:0] dev_tx_char,
    input logic              rx_flag,
    input logic              tx_flag,
    input logic              cpu_inp,
    input logic              cpu_out,
    input logic              cpu_ski,
    input logic              cpu_sko,
    input logic              cpu_ion,
    input logic              cpu_iof,
    input logic              cpu_clr_ien,
    input logic [CHAR_W-1:0] acc_lo_in,
    input logic [CHAR_W-1:0] acc_lo_out,
    input logic              skip_req,
    input logic              irq,
    input logic              ien
);

    // input assumption: one decoded instruction per cycle
    a_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_inp, cpu_out, cpu_ski, cpu_sko, cpu_ion, cpu_iof}));

    a_r2_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_flag && dev_rx_wr) |=> (rx_flag && acc_lo_out == $past(dev_rx_char)));

    a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && dev_rx_wr && !cpu_inp) |=> (rx_flag && $stable(acc_lo_out)));

    a_r4_inp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && cpu_inp) |=> !rx_flag);

    a_r5_out_load: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_out |=> (!tx_flag && dev_tx_char == $past(acc_lo_in)));

    a_r6_tx_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_flag && dev_tx_rd && !cpu_out) |=> tx_flag);

    a_r6_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && dev_tx_rd && !cpu_out) |=> (tx_flag && $stable(dev_tx_char)));

    a_r7_skip_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ski && rx_flag) |-> skip_req);

    a_r7_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_ski && rx_flag) && !(cpu_sko && tx_flag)) |-> !skip_req);

    a_r8_iof_off: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_iof |=> !irq);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clr_ien |=> !irq);

    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && (rx_flag || tx_flag)));

endmodule

bind term_flag_io term_flag_io_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_rx_wr   (dev_rx_wr),
    .dev_rx_char (dev_rx_char),
    .dev_tx_rd   (dev_tx_rd),
    .dev_tx_char (dev_tx_char),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag),
    .cpu_inp     (cpu_inp),
    .cpu_out     (cpu_out),
    .cpu_ski     (cpu_ski),
    .cpu_sko     (cpu_sko),
    .cpu_ion     (cpu_ion),
    .cpu_iof     (cpu_iof),
    .cpu_clr_ien (cpu_clr_ien),
    .acc_lo_in   (acc_lo_in),
    .acc_lo_out  (acc_lo_out),
    .skip_req    (skip_req),
    .irq         (irq),
    .ien         (ien_q)
);

// File: tb/tb_term_flag_io.sv
module tb_term_flag_io;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_rx_wr = 1'b0;
    logic [7:0] dev_rx_char = '0;
    logic       dev_tx_rd = 1'b0;
    logic [7:0] dev_tx_char;
    logic       rx_flag, tx_flag;
    logic       cpu_inp = 1'b0, cpu_out = 1'b0, cpu_ski = 1'b0, cpu_sko = 1'b0;
    logic       cpu_ion = 1'b0, cpu_iof = 1'b0, cpu_clr_ien = 1'b0;
    logic [7:0] acc_lo_in = '0;
    logic [7:0] acc_lo_out;
    logic       skip_req, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_flag_io dut (
        .clk(clk), .rst_n(rst_n),
        .dev_rx_wr(dev_rx_wr), .dev_rx_char(dev_rx_char),
        .dev_tx_rd(dev_tx_rd), .dev_tx_char(dev_tx_char),
        .rx_flag(rx_flag), .tx_flag(tx_flag),
        .cpu_inp(cpu_inp), .cpu_out(cpu_out), .cpu_ski(cpu_ski), .cpu_sko(cpu_sko),
        .cpu_ion(cpu_ion), .cpu_iof(cpu_iof), .cpu_clr_ien(cpu_clr_ien),
        .acc_lo_in(acc_lo_in), .acc_lo_out(acc_lo_out),
        .skip_req(skip_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock step: inputs driven before, all strobes dropped after
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        dev_rx_wr = 0; dev_tx_rd = 0;
        cpu_inp = 0; cpu_out = 0; cpu_ski = 0; cpu_sko = 0;
        cpu_ion = 0; cpu_iof = 0; cpu_clr_ien = 0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 rx_flag", {7'd0, rx_flag}, 8'd0);
        check("R1 tx_flag", {7'd0, tx_flag}, 8'd1);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 rx char", acc_lo_out, 8'h00);
        check("R1 tx char", dev_tx_char, 8'h00);
    endtask

    task automatic t_rx_path();
        dev_rx_char = 8'h41; dev_rx_wr = 1; step();
        check("R2 flag set", {7'd0, rx_flag}, 8'd1);
        check("R2 char", acc_lo_out, 8'h41);
        cpu_inp = 1; #1;
        check("R4 acc byte during inp", acc_lo_out, 8'h41);
        step();
        check("R4 flag cleared", {7'd0, rx_flag}, 8'd0);
    endtask

    task automatic t_rx_overrun();
        dev_rx_char = 8'h55; dev_rx_wr = 1; step();
        dev_rx_char = 8'h66; dev_rx_wr = 1; step();
        check("R3 char kept", acc_lo_out, 8'h55);
        check("R3 flag kept", {7'd0, rx_flag}, 8'd1);
        cpu_inp = 1; step();
    endtask

    task automatic t_tx_path();
        acc_lo_in = 8'h5A; cpu_out = 1; step();
        check("R5 flag cleared", {7'd0, tx_flag}, 8'd0);
        check("R5 char", dev_tx_char, 8'h5A);
        dev_tx_rd = 1; step();
        check("R6 consume sets flag", {7'd0, tx_flag}, 8'd1);
        dev_tx_rd = 1; step();
        check("R6 idle read flag", {7'd0, tx_flag}, 8'd1);
        check("R6 idle read char", dev_tx_char, 8'h5A);
    endtask

    task automatic t_skip();
        cpu_ski = 1; #1;
        check("R7 ski flag0", {7'd0, skip_req}, 8'd0);
        cpu_ski = 0; cpu_sko = 1; #1;
        check("R7 sko flag1", {7'd0, skip_req}, 8'd1);
        step();
        dev_rx_char = 8'h12; dev_rx_wr = 1; step();
        cpu_ski = 1; #1;
        check("R7 ski flag1", {7'd0, skip_req}, 8'd1);
        step();
        cpu_inp = 1; step();
        acc_lo_in = 8'h34; cpu_out = 1; step();
        cpu_sko = 1; #1;
        check("R7 sko flag0", {7'd0, skip_req}, 8'd0);
        step();
        dev_tx_rd = 1; step();
    endtask

    task automatic t_ien();
        cpu_ion = 1; step();
        check("R8 ion irq", {7'd0, irq}, 8'd1);
        cpu_iof = 1; step();
        check("R8 iof irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_clear_priority();
        cpu_ion = 1; cpu_clr_ien = 1; step();
        check("R9 clear beats ion", {7'd0, irq}, 8'd0);
        cpu_ion = 1; step();
        check("R9 ion after", {7'd0, irq}, 8'd1);
        cpu_clr_ien = 1; step();
        check("R9 clear alone", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_irq_gate();
        cpu_ion = 1; step();
        acc_lo_in = 8'h01; cpu_out = 1; step();
        check("R10 no flags irq", {7'd0, irq}, 8'd0);
        dev_rx_char = 8'h02; dev_rx_wr = 1; step();
        check("R10 rx flag irq", {7'd0, irq}, 8'd1);
        cpu_inp = 1; step();
        dev_tx_rd = 1; step();
        check("R10 tx flag irq", {7'd0, irq}, 8'd1);
        cpu_iof = 1; step();
    endtask

    task automatic t_same_cycle();
        dev_rx_char = 8'h77; dev_rx_wr = 1; cpu_inp = 1; step();
        check("R11 rx write wins flag", {7'd0, rx_flag}, 8'd1);
        check("R11 rx write wins char", acc_lo_out, 8'h77);
        cpu_inp = 1; step();
        acc_lo_in = 8'h11; cpu_out = 1; step();
        acc_lo_in = 8'h22; cpu_out = 1; dev_tx_rd = 1; step();
        check("R11 out wins flag", {7'd0, tx_flag}, 8'd0);
        check("R11 out wins char", dev_tx_char, 8'h22);
        dev_tx_rd = 1; step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_rx_path();
        t_rx_overrun();
        t_tx_path();
        t_skip();
        t_ien();
        t_clear_priority();
        t_irq_gate();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule